// File: doc/BRIEF.md
# Address Translation Cache with Two-Level Table Walker

This block translates 32-bit virtual addresses into physical addresses for 4 KiB pages. It keeps 64 recent translations in a 4-way set-associative array of 16 sets. Within a set, the entry that was used least recently is the one replaced. A lookup that misses starts a hardware walk of a two-level page table in memory. The walk issues two dependent single-word reads through a read port. The resulting translation is installed in the array and returned to the requester.

The core side uses two valid/ready streams. On the request stream, a request transfers on a cycle in which both `req_valid_i` and `req_ready_o` are high. The requester holds the request stable until then. On the response stream, a response stays valid, with its data held stable, until `rsp_ready_i` is high on a clock edge.

`req_ready_o` is low in two cases: while a walk is in progress, and while an earlier response is waiting to be taken. Only one walk is outstanding at a time. A lookup marked as a prefetch returns a response only if it hits; on a miss it is silently dropped. A single-cycle flush pulse clears every translation, as at a context switch.

Top module: `xlat_cache`

## Requirements
- R1: A translated address carries virtual bits 11:0 unchanged in bits 11:0. Bits 31:12 come from the physical page number of the matching translation.
- R2: A miss reads the first-level word at {pt_base_i, va[31:22], 2'b00}. Only after that word returns does it read the second-level word at {word1[31:12], va[21:12], 2'b00}. A read address stays stable while the read request waits for `mem_req_ready_i`.
- R3: After a successful walk, the translation is installed. A later lookup of the same page hits without any memory read, and its response is valid on the cycle after the request transfers.
- R4: A table word with bit 0 clear, at either level, ends the walk with `rsp_fault_o` high. A first-level fault issues no second read. Nothing is installed, so a repeated lookup walks again.
- R5: A prefetch lookup (`req_pref_i` high) that misses produces no memory read and no response. A prefetch lookup that hits responds like a normal lookup.
- R6: `req_ready_o` is high when idle after reset. It is low for the whole of a walk, and low while an untaken response is pending.
- R7: Within a set, a miss fills an invalid way first. Otherwise it replaces the least recently used way; both hits and installs count as uses.
- R8: A `flush_i` pulse invalidates all entries, so every later lookup misses.
- R9: If `flush_i` arrives while a walk is in progress, the walk still returns its translation, but the translation is not installed.
- R10: A response whose `rsp_ready_i` is low keeps `rsp_valid_o`, `rsp_paddr_o` and `rsp_fault_o` unchanged until it is taken.
- R11: The set is chosen by va[15:12], and the tag is va[31:16]. All 64 entries can hold distinct pages at once: 16 sets, each with 4 tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all translations |
| pt_base_i | input | 20 | Bits 31:12 of the first-level table address |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted this cycle |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_pref_i | input | 1 | Lookup is a prefetch (dropped on a miss) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_paddr_o | output | 32 | Physical address (zero on a fault) |
| rsp_fault_o | output | 1 | The walk met a non-present table word |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Word address of the table read |
| mem_rsp_valid_i | input | 1 | Read data valid (one per accepted read) |
| mem_rsp_data_i | input | 32 | Table word; bit 0 present, bits 31:12 page number |

## Verification
A corrupted valid bit or tag shows up at the ports as an unexpected memory read, or a missing one, on the very next lookup of that page. So the bench counts table reads for each lookup, rather than only checking the returned address. Wrong replacement order shows only after one full cycle through a set: four fills, a touch, and a fifth install. The bench then re-reads every page in that set, and the one page that walks again identifies the way that was evicted. A walker that builds a wrong table address returns a wrong page number within about five cycles of the request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ADDR_W = 32;
  localparam int PG_W   = 12;
  localparam int LVL_W  = 10;
  localparam int PN_W   = ADDR_W - PG_W;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD1,
    WK_WT1,
    WK_RD2,
    WK_WT2
  } walk_st_e;
endpackage

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch_i,
  input  logic [$clog2(WAYS)-1:0] way_i,
  output logic [$clog2(WAYS)-1:0] oldest_o
);
  localparam int WW = $clog2(WAYS);

  // Age 0 marks the most recently used way; WAYS-1 marks the oldest.
  logic [WW-1:0]   age_q [WAYS];
  logic [WAYS-1:0] is_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WW'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == way_i)              age_q[w] <= '0;
        else if (age_q[w] < age_q[way_i]) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      is_old[w] = (age_q[w] == WW'(WAYS - 1));
      if (is_old[w]) oldest_o = WW'(w);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(is_old)); // R7
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PN_W-1:0]   vpn_i,
  input  logic [PN_W-1:0]   base_i,
  output logic              busy_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [PN_W-1:0]   ppn_o
);
  walk_st_e        st_q;
  logic [PN_W-1:0] vpn_q;
  logic [PN_W-1:0] base_q;
  logic [PN_W-1:0] nxt_q;
  logic            present;

  assign present = mem_rsp_data_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      vpn_q  <= '0;
      base_q <= '0;
      nxt_q  <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start_i) begin
          vpn_q  <= vpn_i;
          base_q <= base_i;
          st_q   <= WK_RD1;
        end
        WK_RD1: if (mem_ready_i) st_q <= WK_WT1;
        WK_WT1: if (mem_rsp_valid_i) begin
          if (present) begin
            nxt_q <= mem_rsp_data_i[WORD_W-1 -: PN_W];
            st_q  <= WK_RD2;
          end else begin
            st_q <= WK_IDLE;
          end
        end
        WK_RD2: if (mem_ready_i) st_q <= WK_WT2;
        WK_WT2: if (mem_rsp_valid_i) st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o      = (st_q != WK_IDLE);
    mem_valid_o = (st_q == WK_RD1) || (st_q == WK_RD2);
    if (st_q == WK_RD2)
      mem_addr_o = {nxt_q, vpn_q[LVL_W-1:0], 2'b00};
    else
      mem_addr_o = {base_q, vpn_q[PN_W-1 -: LVL_W], 2'b00};
    done_o  = mem_rsp_valid_i &&
              (((st_q == WK_WT1) && !present) || (st_q == WK_WT2));
    fault_o = !present;
    ppn_o   = mem_rsp_data_i[WORD_W-1 -: PN_W];
  end

  AST_MEM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)); // R2
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (st_q == WK_IDLE)); // R6
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N_SETS = 16,
  parameter int N_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [19:0]       pt_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_vaddr_i,
  input  logic              req_pref_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [31:0]       mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i
);
  localparam int SET_W = $clog2(N_SETS);
  localparam int WW    = $clog2(N_WAYS);
  localparam int TAG_W = ADDR_W - PG_W - SET_W;

  logic [N_WAYS-1:0] valid_q [N_SETS];
  logic [TAG_W-1:0]  tag_q   [N_SETS][N_WAYS];
  logic [PN_W-1:0]   ppn_q   [N_SETS][N_WAYS];
  logic [WW-1:0]     oldest  [N_SETS];

  logic [SET_W-1:0]  lk_set, wk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [N_WAYS-1:0] hit_vec;
  logic              hit;
  logic [WW-1:0]     hit_way, victim;
  logic [PN_W-1:0]   hit_ppn;
  logic              req_fire, wk_start, install, stale_q, any_valid;
  logic [ADDR_W-1:0] wk_va_q;
  logic              wk_busy, wk_done, wk_fault;
  logic [PN_W-1:0]   wk_ppn;
  logic              touch_en;
  logic [SET_W-1:0]  touch_set;
  logic [WW-1:0]     touch_way;
  logic              rsp_valid_q, rsp_fault_q;
  logic [ADDR_W-1:0] rsp_paddr_q;

  // Lookup path
  assign lk_set = req_vaddr_i[PG_W +: SET_W];
  assign lk_tag = req_vaddr_i[ADDR_W-1 -: TAG_W];
  assign wk_set = wk_va_q[PG_W +: SET_W];

  for (genvar w = 0; w < N_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    hit_ppn = '0;
    for (int w = 0; w < N_WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WW'(w);
        hit_ppn = ppn_q[lk_set][w];
      end
    end
  end
  assign hit = |hit_vec;

  assign req_ready_o = !wk_busy && (!rsp_valid_q || rsp_ready_i);
  assign req_fire    = req_valid_i && req_ready_o;
  assign wk_start    = req_fire && !hit && !req_pref_i;
  assign install     = wk_done && !wk_fault && !stale_q && !flush_i;

  // Victim: an invalid way first, otherwise the set's oldest way
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = oldest[wk_set];
    for (int w = 0; w < N_WAYS; w++) begin
      if (!found && !valid_q[wk_set][w]) begin
        victim = WW'(w);
        found  = 1'b1;
      end
    end
  end

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SETS; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < N_SETS; s++) valid_q[s] <= '0;
    end else if (install) begin
      valid_q[wk_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[wk_set][victim] <= wk_va_q[ADDR_W-1 -: TAG_W];
      ppn_q[wk_set][victim] <= wk_ppn;
    end
  end

  // Replacement order, one tracker per set
  assign touch_en  = (req_fire && hit) || install;
  assign touch_set = install ? wk_set : lk_set;
  assign touch_way = install ? victim : hit_way;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    xlat_lru #(.WAYS(N_WAYS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_i  (touch_en && (touch_set == SET_W'(s))),
      .way_i    (touch_way),
      .oldest_o (oldest[s])
    );
  end

  // Walk bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_va_q <= '0;
      stale_q <= 1'b0;
    end else if (wk_start) begin
      wk_va_q <= req_vaddr_i;
      stale_q <= 1'b0;
    end else if (flush_i && wk_busy) begin
      stale_q <= 1'b1;
    end
  end

  xlat_walker u_walk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (wk_start),
    .vpn_i           (req_vaddr_i[ADDR_W-1:PG_W]),
    .base_i          (pt_base_i),
    .busy_o          (wk_busy),
    .mem_valid_o     (mem_req_valid_o),
    .mem_ready_i     (mem_req_ready_i),
    .mem_addr_o      (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .done_o          (wk_done),
    .fault_o         (wk_fault),
    .ppn_o           (wk_ppn)
  );

  // Response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= 1'b0;
    end else if (req_fire && hit) begin
      rsp_valid_q <= 1'b1;
      rsp_paddr_q <= {hit_ppn, req_vaddr_i[PG_W-1:0]};
      rsp_fault_q <= 1'b0;
    end else if (wk_done) begin
      rsp_valid_q <= 1'b1;
      rsp_paddr_q <= wk_fault ? '0 : {wk_ppn, wk_va_q[PG_W-1:0]};
      rsp_fault_q <= wk_fault;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_paddr_o = rsp_paddr_q;
  assign rsp_fault_o = rsp_fault_q;

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < N_SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !any_valid); // R8
  AST_PREF_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && req_pref_i && !hit |=> !wk_busy); // R5
  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_DONE_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wk_done |-> !rsp_valid_q); // R6
endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [19:0] base = 20'h00100;
  logic        req_valid = 1'b0, req_pref = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_rsp_valid = 1'b0;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_addr, mem_rsp_data = '0;
  int          rd_cnt = 0;
  logic [31:0] last_addr = '0, prev_addr = '0;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  xlat_cache dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .pt_base_i(base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_pref_i(req_pref), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  // Table contents: level 1 points to page {10'h201, idx1}; idx 3FF is absent.
  function automatic logic [31:0] table_word(input logic [31:0] a);
    if (a[31:12] == 20'h00100)
      return (a[11:2] == 10'h3FF) ? 32'h0 : {10'h201, a[11:2], 11'b0, 1'b1};
    else if (a[31:22] == 10'h201)
      return (a[11:2] == 10'h3FF) ? 32'h0 : {a[21:12] ^ 10'h155, a[11:2], 11'b0, 1'b1};
    else
      return 32'h0;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] va);
    return {va[31:22] ^ 10'h155, va[21:0]};
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= table_word(mem_addr);
      rd_cnt        <= rd_cnt + 1;
      prev_addr     <= last_addr;
      last_addr     <= mem_addr;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic pf, input int flush_at,
                        output logic got, output logic [31:0] pa, output logic flt,
                        output int lat, output int nrd, output logic rdy_seen);
    int r0;
    r0 = rd_cnt;
    got = 1'b0; pa = '0; flt = 1'b0; lat = 0; rdy_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_pref = pf;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_pref = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      flush = (k == flush_at);
      if (rsp_valid) begin
        got = 1'b1; pa = rsp_paddr; flt = rsp_fault; lat = k;
        break;
      end
      if (req_ready) rdy_seen = 1'b1;
      @(negedge clk);
    end
    flush = 1'b0;
    @(negedge clk);
    nrd = rd_cnt - r0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  logic got, flt, rdy;
  logic [31:0] pa;
  int lat, nrd;

  task automatic t_reset();
    check("R6 ready after reset", {31'b0, req_ready}, 32'h1);
    check("R6 no response after reset", {31'b0, rsp_valid}, 32'h0);
    check("R2 no table read after reset", {31'b0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_walk();
    lookup(32'h1234_5678, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R1 walk paddr", pa, exp_pa(32'h1234_5678));
    check("R2 two table reads", nrd, 2);
    check("R2 first read addr", prev_addr, {20'h00100, 10'h048, 2'b00});
    check("R2 second read addr", last_addr, {10'h201, 10'h048, 10'h345, 2'b00});
    check("R6 ready low during walk", {31'b0, rdy}, 32'h0);
  endtask

  task automatic t_hit();
    lookup(32'h1234_5ABC, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R3 hit no reads", nrd, 0);
    check("R3 hit latency", lat, 1);
    check("R1 hit offset passthrough", pa, exp_pa(32'h1234_5ABC));
  endtask

  task automatic t_fault();
    lookup(32'hFFC0_1000, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R4 level-1 fault flag", {31'b0, flt}, 32'h1);
    check("R4 level-1 fault one read", nrd, 1);
    lookup(32'h003F_F123, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R4 level-2 fault flag", {31'b0, flt}, 32'h1);
    check("R4 level-2 fault two reads", nrd, 2);
    lookup(32'h003F_F123, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R4 fault not installed", nrd, 2);
  endtask

  task automatic t_prefetch();
    lookup(32'h0BAD_0000, 1'b1, 0, got, pa, flt, lat, nrd, rdy);
    check("R5 prefetch miss no response", {31'b0, got}, 32'h0);
    check("R5 prefetch miss no reads", nrd, 0);
    lookup(32'h1234_5004, 1'b1, 0, got, pa, flt, lat, nrd, rdy);
    check("R5 prefetch hit responds", {31'b0, got}, 32'h1);
    check("R5 prefetch hit paddr", pa, exp_pa(32'h1234_5004));
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = 32'h1234_5010;
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_paddr;
    check("R10 response valid", {31'b0, rsp_valid}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held valid", {31'b0, rsp_valid}, 32'h1);
      check("R10 held paddr", rsp_paddr, first);
      check("R6 ready low while pending", {31'b0, req_ready}, 32'h0);
    end
    check("R10 paddr value", first, exp_pa(32'h1234_5010));
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 response taken", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_flush();
    do_flush();
    lookup(32'h1234_5678, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R8 walk after flush", nrd, 2);
  endtask

  task automatic t_flush_walk();
    lookup(32'h0777_7000, 1'b0, 2, got, pa, flt, lat, nrd, rdy);
    check("R9 walk result delivered", pa, exp_pa(32'h0777_7000));
    lookup(32'h0777_7000, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R9 not installed", nrd, 2);
  endtask

  task automatic t_lru();
    logic [31:0] pg [5];
    int rds [6];
    int order [6];
    pg[0] = 32'h0001_5000; pg[1] = 32'h0002_5000; pg[2] = 32'h0003_5000;
    pg[3] = 32'h0004_5000; pg[4] = 32'h0005_5000;
    do_flush();
    for (int i = 0; i < 4; i++) lookup(pg[i], 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    lookup(pg[0], 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R7 touched way hits", nrd, 0);
    lookup(pg[4], 1'b0, 0, got, pa, flt, lat, nrd, rdy);
    check("R7 fifth page walks", nrd, 2);
    order[0] = 0; order[1] = 2; order[2] = 3; order[3] = 4; order[4] = 1;
    for (int i = 0; i < 5; i++) begin
      lookup(pg[order[i]], 1'b0, 0, got, pa, flt, lat, nrd, rdy);
      rds[i] = nrd;
    end
    check("R7 recent page kept A", rds[0], 0);
    check("R7 recent page kept C", rds[1], 0);
    check("R7 recent page kept D", rds[2], 0);
    check("R7 new page kept", rds[3], 0);
    check("R7 least recent evicted", rds[4], 2);
  endtask

  task automatic t_capacity();
    int total, bad;
    logic [31:0] va;
    total = 0; bad = 0;
    do_flush();
    for (int s = 0; s < 16; s++)
      for (int t = 1; t <= 4; t++) begin
        va = {16'(t), 4'(s), 12'h020};
        lookup(va, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
      end
    for (int s = 0; s < 16; s++)
      for (int t = 1; t <= 4; t++) begin
        va = {16'(t), 4'(s), 12'h020};
        lookup(va, 1'b0, 0, got, pa, flt, lat, nrd, rdy);
        total += nrd;
        if (pa !== exp_pa(va)) bad++;
      end
    check("R11 all 64 resident", total, 0);
    check("R11 all 64 paddrs", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_hit();
    t_fault();
    t_prefetch();
    t_backpressure();
    t_flush();
    t_flush_walk();
    t_lru();
    t_capacity();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule